// File: doc/BRIEF.md
# Hamming ECC Check and Single-Bit Correction Unit

This unit takes two 3-byte Hamming codes for one 512-byte data chunk: the code read back from the spare area, and the code recomputed over the data as it streamed in. It turns each code into a 32-bit word, XORs the two words into a syndrome, counts the set bits and classifies the result. A chunk can be clean, carry one bad data bit that can be repaired, be a blank erased chunk, have a damaged code field, or be beyond repair. A full 2048-byte page is handled by running the unit four times, once for each chunk with that chunk's own three code bytes.

When exactly one data bit is wrong, the unit repairs it in place. It issues a read of the faulty byte on an external byte-wide buffer port, and on the next cycle it writes that byte back with the faulty bit inverted. Every accepted start produces exactly one done pulse. The status and the correction location stay on the outputs until the next operation reaches its evaluation cycle.

Top module: `ecc_fix_unit`

## Requirements
- R1: Each 24-bit code input is taken as byte0 = bits [7:0], byte1 = bits [15:8] and byte2 = bits [23:16]. It is repacked into a 32-bit word with byte0 at [7:0], byte1 at [23:16], the upper nibble of byte2 at [27:24] and the lower nibble of byte2 at [11:8]; all other bits are zero. The syndrome is the XOR of the two repacked words. A zero syndrome reports status 0 and performs no buffer write.
- R2: A syndrome with exactly 12 set bits is a correctable error, whatever the bit pattern. It reports status 0, fix_bit_o = syndrome[18:16] and fix_byte_o = syndrome[27:19], and the addressed buffer byte has that bit inverted.
- R3: A syndrome with exactly 1 set bit reports status 2 (damaged code field) and leaves the buffer untouched.
- R4: A stored code of all ones (repacked 0x0FFF0FFF) together with a computed code of all zeros reports status 1 (erased chunk) and leaves the buffer untouched.
- R5: Every other nonzero syndrome reports status 3 (uncorrectable) and leaves the buffer untouched. This includes a stored code of all zeros against a computed code of all ones.
- R6: Each accepted start gives exactly one done pulse, one cycle wide. Done is high in the 2nd cycle after the start edge when no repair is made, and in the 4th cycle after it when a repair is made.
- R7: A start that arrives while an operation is in progress is ignored. The operation in progress completes with the codes latched at its own start.
- R8: A repair is one read request for the faulty byte, followed on the next cycle by one write to the same address. The write data is the returned read data XOR a one-hot mask at fix_bit_o. No other byte is written.
- R9: After reset, done_o, buf_re_o and buf_we_o are low, and status_o, fix_byte_o and fix_bit_o are zero.
- R10: fix_byte_o and fix_bit_o read zero for any result other than a repair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; sampled only when idle |
| stored_ecc_i | input | 24 | Code read from the spare area |
| calc_ecc_i | input | 24 | Code recomputed over the chunk |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok/repaired, 1 erased, 2 code field damaged, 3 uncorrectable |
| fix_byte_o | output | 9 | Byte index of the repaired bit |
| fix_bit_o | output | 3 | Bit index of the repaired bit |
| buf_addr_o | output | 9 | Buffer byte address |
| buf_re_o | output | 1 | Buffer read request; data returns next cycle |
| buf_rdata_i | input | 8 | Buffer read data |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |

## Verification
On every cycle the assertions check the shape of the buffer traffic. A write always follows a read of the same address, flips exactly one bit of the returned data, occurs only with a repair status, and is followed by done. Done is never wider than one cycle. Whether the classification is right depends on the code values presented, so only the bench scenarios can show it. These scenarios cover all 4096 byte and bit locations, every single-bit and two-bit raw code fault, the erased pair and its reverse, a weight-12 pattern that is not a clean location pattern, and a start held high through a busy operation.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int unsigned RAW_W  = 24;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_ERASED = 2'd1,
    ST_CODE   = 2'd2,
    ST_FATAL  = 2'd3
  } ecc_stat_e;
endpackage

// File: rtl/ecc_repack.sv
module ecc_repack
  import ecc_fix_pkg::*;
(
  input  logic [RAW_W-1:0]  raw_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o        = '0;
    word_o[7:0]   = raw_i[7:0];
    word_o[23:16] = raw_i[15:8];
    word_o[27:24] = raw_i[23:20];
    word_o[11:8]  = raw_i[19:16];
  end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_fix_pkg::*;
#(
  parameter int unsigned ADDR_W        = 9,
  parameter int unsigned BIT_W         = 3,
  parameter int unsigned FIX_WEIGHT    = 12,
  parameter logic [31:0] ERASED_STORED = 32'h0FFF_0FFF,
  parameter logic [31:0] ERASED_CALC   = 32'h0000_0000
) (
  input  logic [WORD_W-1:0] stored_w_i,
  input  logic [WORD_W-1:0] calc_w_i,
  output ecc_stat_e         status_o,
  output logic              fix_en_o,
  output logic [ADDR_W-1:0] fix_byte_o,
  output logic [BIT_W-1:0]  fix_bit_o
);
  localparam int unsigned CNT_W   = $clog2(WORD_W + 1);
  localparam int unsigned LOC_LSB = 16;
  localparam logic [CNT_W-1:0] FIX_CNT = CNT_W'(FIX_WEIGHT);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [WORD_W-1:0] syn;
  logic [CNT_W-1:0]  weight;

  assign syn = stored_w_i ^ calc_w_i;

  always_comb begin
    weight = '0;
    for (int i = 0; i < int'(WORD_W); i++) weight = weight + CNT_W'(syn[i]);
  end

  always_comb begin
    status_o   = ST_OK;
    fix_en_o   = 1'b0;
    fix_byte_o = '0;
    fix_bit_o  = '0;
    if (syn == '0) begin
      status_o = ST_OK;
    end else if (weight == FIX_CNT) begin
      fix_en_o   = 1'b1;
      fix_bit_o  = syn[LOC_LSB +: BIT_W];
      fix_byte_o = syn[LOC_LSB+BIT_W +: ADDR_W];
    end else if (weight == ONE_CNT) begin
      status_o = ST_CODE;
    end else if (stored_w_i == ERASED_STORED && calc_w_i == ERASED_CALC) begin
      status_o = ST_ERASED;
    end else begin
      status_o = ST_FATAL;
    end
  end
endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_fix_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BIT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  ecc_stat_e         status_i,
  input  logic              fix_en_i,
  input  logic [ADDR_W-1:0] fix_byte_i,
  input  logic [BIT_W-1:0]  fix_bit_i,
  input  logic [BYTE_W-1:0] buf_rdata_i,
  output logic              accept_o,
  output logic [1:0]        status_o,
  output logic [ADDR_W-1:0] fix_byte_o,
  output logic [BIT_W-1:0]  fix_bit_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              buf_re_o,
  output logic              buf_we_o,
  output logic [BYTE_W-1:0] buf_wdata_o,
  output logic              done_o
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_READ, S_WRITE, S_FIN} fsm_e;

  fsm_e              state_q;
  ecc_stat_e         status_q;
  logic [ADDR_W-1:0] byte_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] mask;

  assign accept_o = (state_q == S_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      byte_q   <= '0;
      bit_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE:  if (start_i) state_q <= S_EVAL;
        S_EVAL: begin
          status_q <= status_i;
          byte_q   <= fix_en_i ? fix_byte_i : '0;
          bit_q    <= fix_en_i ? fix_bit_i : '0;
          state_q  <= fix_en_i ? S_READ : S_FIN;
        end
        S_READ:  state_q <= S_WRITE;
        S_WRITE: state_q <= S_FIN;
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mask        = '0;
    mask[bit_q] = 1'b1;
  end

  assign status_o    = status_q;
  assign fix_byte_o  = byte_q;
  assign fix_bit_o   = bit_q;
  assign buf_addr_o  = byte_q;
  assign buf_re_o    = (state_q == S_READ);
  assign buf_we_o    = (state_q == S_WRITE);
  assign buf_wdata_o = buf_rdata_i ^ mask;
  assign done_o      = (state_q == S_FIN);
endmodule

// File: rtl/ecc_fix_unit.sv
module ecc_fix_unit
  import ecc_fix_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 512,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [RAW_W-1:0]               stored_ecc_i,
  input  logic [RAW_W-1:0]               calc_ecc_i,
  output logic                           done_o,
  output logic [1:0]                     status_o,
  output logic [$clog2(CHUNK_BYTES)-1:0] fix_byte_o,
  output logic [$clog2(BYTE_W)-1:0]      fix_bit_o,
  output logic [$clog2(CHUNK_BYTES)-1:0] buf_addr_o,
  output logic                           buf_re_o,
  input  logic [BYTE_W-1:0]              buf_rdata_i,
  output logic                           buf_we_o,
  output logic [BYTE_W-1:0]              buf_wdata_o
);
  localparam int unsigned ADDR_W = $clog2(CHUNK_BYTES);
  localparam int unsigned BIT_W  = $clog2(BYTE_W);

  logic [RAW_W-1:0]  stored_q, calc_q;
  logic [WORD_W-1:0] stored_w, calc_w;
  logic              accept;
  ecc_stat_e         cls_status;
  logic              cls_fix_en;
  logic [ADDR_W-1:0] cls_byte;
  logic [BIT_W-1:0]  cls_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stored_q <= '0;
      calc_q   <= '0;
    end else if (accept) begin
      stored_q <= stored_ecc_i;
      calc_q   <= calc_ecc_i;
    end
  end

  ecc_repack u_rp_stored (.raw_i(stored_q), .word_o(stored_w));
  ecc_repack u_rp_calc   (.raw_i(calc_q),   .word_o(calc_w));

  ecc_classify #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_cls (
    .stored_w_i (stored_w),
    .calc_w_i   (calc_w),
    .status_o   (cls_status),
    .fix_en_o   (cls_fix_en),
    .fix_byte_o (cls_byte),
    .fix_bit_o  (cls_bit)
  );

  ecc_rmw_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BIT_W(BIT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .status_i    (cls_status),
    .fix_en_i    (cls_fix_en),
    .fix_byte_i  (cls_byte),
    .fix_bit_i   (cls_bit),
    .buf_rdata_i (buf_rdata_i),
    .accept_o    (accept),
    .status_o    (status_o),
    .fix_byte_o  (fix_byte_o),
    .fix_bit_o   (fix_bit_o),
    .buf_addr_o  (buf_addr_o),
    .buf_re_o    (buf_re_o),
    .buf_we_o    (buf_we_o),
    .buf_wdata_o (buf_wdata_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/ecc_fix_unit_chk.sv
module ecc_fix_unit_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BIT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [1:0]        status_o,
  input logic [ADDR_W-1:0] fix_byte_o,
  input logic [BIT_W-1:0]  fix_bit_o,
  input logic [ADDR_W-1:0] buf_addr_o,
  input logic              buf_re_o,
  input logic [BYTE_W-1:0] buf_rdata_i,
  input logic              buf_we_o,
  input logic [BYTE_W-1:0] buf_wdata_o
);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  rd_before_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> $past(buf_re_o) && buf_addr_o == $past(buf_addr_o));
  // R8
  wr_one_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> $countones(buf_wdata_o ^ buf_rdata_i) == 1);
  // R8
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({buf_re_o, buf_we_o, done_o}));
  // R6
  wr_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |=> done_o);
  // R2
  wr_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> status_o == 2'd0 && buf_addr_o == fix_byte_o);
  // R10
  loc_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o != 2'd0) |-> (fix_byte_o == '0 && fix_bit_o == '0));
endmodule

bind ecc_fix_unit ecc_fix_unit_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BIT_W(BIT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .status_o    (status_o),
  .fix_byte_o  (fix_byte_o),
  .fix_bit_o   (fix_bit_o),
  .buf_addr_o  (buf_addr_o),
  .buf_re_o    (buf_re_o),
  .buf_rdata_i (buf_rdata_i),
  .buf_we_o    (buf_we_o),
  .buf_wdata_o (buf_wdata_o)
);

// File: tb/ecc_fix_unit_test.sv
module ecc_fix_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored = '0, calc = '0;
  logic        done_o, buf_re_o, buf_we_o;
  logic [1:0]  status_o;
  logic [8:0]  fix_byte_o, buf_addr_o;
  logic [2:0]  fix_bit_o;
  logic [7:0]  buf_rdata, buf_wdata_o;

  int checks = 0, failures = 0;
  int wr_cnt = 0, done_cnt = 0;
  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];

  always #4 clk = ~clk;

  ecc_fix_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .stored_ecc_i(stored), .calc_ecc_i(calc),
    .done_o(done_o), .status_o(status_o),
    .fix_byte_o(fix_byte_o), .fix_bit_o(fix_bit_o),
    .buf_addr_o(buf_addr_o), .buf_re_o(buf_re_o), .buf_rdata_i(buf_rdata),
    .buf_we_o(buf_we_o), .buf_wdata_o(buf_wdata_o)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  // external buffer with one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 512; a++) mem[a] <= pat(a);
      buf_rdata <= '0;
    end else begin
      if (buf_re_o) buf_rdata <= mem[buf_addr_o];
      if (buf_we_o) begin
        mem[buf_addr_o] <= buf_wdata_o;
        wr_cnt++;
      end
      if (done_o) done_cnt++;
    end
  end

  function automatic logic [23:0] unpack(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  function automatic logic [31:0] loc_syn(input logic [8:0] b, input logic [2:0] t);
    logic [11:0] idx;
    idx = {b, t};
    return {4'h0, idx, 4'h0, ~idx};
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_op(input logic [23:0] st, input logic [23:0] cl, output int lat,
                        output logic [1:0] s, output logic [8:0] fb, output logic [2:0] ft,
                        output int wrs, output int dns);
    int w0, d0;
    w0 = wr_cnt; d0 = done_cnt;
    stored = st; calc = cl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done_o && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    s = status_o; fb = fix_byte_o; ft = fix_bit_o;
    @(negedge clk);
    @(negedge clk);
    wrs = wr_cnt - w0; dns = done_cnt - d0;
  endtask

  // expect a non-repair outcome
  task automatic expect_plain(input string req, input logic [23:0] st, input logic [23:0] cl,
                              input logic [1:0] exp_s);
    int lat, wrs, dns;
    logic [1:0] s; logic [8:0] fb; logic [2:0] ft;
    run_op(st, cl, lat, s, fb, ft, wrs, dns);
    chk({req, " status"}, 32'(s), 32'(exp_s));
    chk({req, " no write"}, 32'(wrs), 0);
    chk("R6 latency", 32'(lat), 2);
    chk("R6 one done", 32'(dns), 1);
    chk("R10 location zero", {20'h0, fb, ft}, 0);
  endtask

  task automatic expect_fix(input logic [23:0] st, input logic [23:0] cl,
                            input logic [8:0] eb, input logic [2:0] et);
    int lat, wrs, dns;
    logic [1:0] s; logic [8:0] fb; logic [2:0] ft;
    run_op(st, cl, lat, s, fb, ft, wrs, dns);
    exp_mem[eb] = exp_mem[eb] ^ (8'h01 << et);
    chk("R2 status", 32'(s), 0);
    chk("R2 byte index", 32'(fb), 32'(eb));
    chk("R2 bit index", 32'(ft), 32'(et));
    chk("R2 R8 byte repaired", 32'(mem[eb]), 32'(exp_mem[eb]));
    chk("R8 one write", 32'(wrs), 1);
    chk("R6 latency", 32'(lat), 4);
    chk("R6 one done", 32'(dns), 1);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int a = 0; a < 512; a++) exp_mem[a] = pat(a);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 done", 32'(done_o), 0);
    chk("R9 re", 32'(buf_re_o), 0);
    chk("R9 we", 32'(buf_we_o), 0);
    chk("R9 status", 32'(status_o), 0);
    chk("R9 location", {20'h0, fix_byte_o, fix_bit_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 clean: equal codes
    for (int i = 0; i < 16; i++) begin
      logic [23:0] v;
      v = 24'((i * 32'h00A3_5C17) ^ (i << 20));
      expect_plain("R1 clean", v, v, 2'd0);
    end
    expect_plain("R1 clean ones", 24'hFFFFFF, 24'hFFFFFF, 2'd0);

    // R3 single raw bit fault in code
    for (int i = 0; i < 24; i++)
      expect_plain("R3 code fault", 24'h5A3C96 ^ (24'h1 << i), 24'h5A3C96, 2'd2);

    // R5 two raw bit faults
    for (int i = 0; i < 24; i++)
      for (int j = i + 1; j < 24; j++)
        expect_plain("R5 double", 24'h13579B ^ (24'h1 << i) ^ (24'h1 << j), 24'h13579B, 2'd3);
    expect_plain("R5 triple", 24'h000007, 24'h000000, 2'd3);

    // R4 erased chunk, and its reverse and near misses
    expect_plain("R4 erased", 24'hFFFFFF, 24'h000000, 2'd1);
    expect_plain("R5 reversed erased", 24'h000000, 24'hFFFFFF, 2'd3);
    expect_plain("R5 near erased", 24'hFFFFFF, 24'h000001, 2'd3);

    // R2 weight-12 pattern that is not a location pattern: bit 7 of byte 1
    expect_fix(24'h000FFF, 24'h000000, 9'd1, 3'd7);

    // R7 start held through a busy repair
    begin
      int w0, d0;
      w0 = wr_cnt; d0 = done_cnt;
      stored = unpack(loc_syn(9'd300, 3'd2)); calc = 24'h0; start = 1'b1;
      @(negedge clk);
      stored = 24'h0; calc = 24'hFFFFFF;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      exp_mem[300] = exp_mem[300] ^ 8'h04;
      chk("R7 done", 32'(done_o), 1);
      chk("R7 status of first", 32'(status_o), 0);
      chk("R7 byte of first", 32'(fix_byte_o), 300);
      repeat (4) @(negedge clk);
      chk("R7 single done", 32'(done_cnt - d0), 1);
      chk("R7 single write", 32'(wr_cnt - w0), 1);
      chk("R7 byte repaired", 32'(mem[300]), 32'(exp_mem[300]));
    end

    // R2 sweep every byte and bit location
    for (int b = 0; b < 512; b++)
      for (int t = 0; t < 8; t++) begin
        logic [31:0] cw;
        cw = (32'(b * 8 + t) * 32'h9E37_79B1) & 32'h0FFF_0FFF;
        expect_fix(unpack(cw ^ loc_syn(9'(b), 3'(t))), unpack(cw), 9'(b), 3'(t));
      end

    // R8 no stray writes anywhere
    for (int a = 0; a < 512; a++)
      chk("R8 buffer contents", 32'(mem[a]), 32'(exp_mem[a]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule